// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous Memory

This block is a single-port synchronous memory whose writes are deferred by one write operation. A command (address, active-low select, active-low write enable and one active-low enable per 9-bit byte lane) is taken on a rising clock edge. For a write, the data word arrives one edge later. That word is held with its address and lane mask in a one-entry write buffer. The buffer only moves into the storage array when the data of the next write is loaded, and any number of reads may come in between.

A read returns its word after the next rising edge. If the read address matches the buffered address, each written lane comes from the buffer and each unwritten lane comes from the array. The output is given as a data word and a drive-enable flag, for an external pad to use. An output-enable input and a power-down input both turn the drive-enable off at once. Power-down also blocks new commands and keeps the stored contents.

Top module: `lwsram_core`

## Requirements
- R1: `addr`, `sel_n`, `wen_n` and `ben_n` are sampled only on the rising edge of `clk`; changes between edges have no effect on the operation performed.
- R2: For a write command sampled at edge N, the data word on `din` is sampled at edge N+1 and becomes that write's buffered data.
- R3: A buffered write reaches the array only when the data of the next write command is loaded. Reads issued in between see the buffered bytes.
- R4: A read whose address equals the buffered write address returns the buffered byte for each lane written by that write and the array byte for every other lane.
- R5: Lane i covers `din`/`dout` bits [9i+8:9i] and is written only when `ben_n[i]` is 0 for that write. A write with `ben_n` all ones changes no stored byte.
- R6: A read command (`sel_n`=0, `wen_n`=1) sampled at edge N drives `dout_en`=1 with the read word on `dout` after edge N+1, until edge N+2.
- R7: A deselect (`sel_n`=1) or write (`sel_n`=0, `wen_n`=0) sampled at edge N gives `dout_en`=0 and `dout`=0 after edge N+1.
- R8: Consecutive reads of the same address, with no write in between, keep `dout` at the same value across the edge.
- R9: While `oe_n` is 1, `dout_en` is 0 and `dout` is 0 at once, whatever the cycle type; clearing `oe_n` restores a pending read word in the same cycle.
- R10: While `pdown` is 1, `dout_en` and `dout` are 0 and commands sampled on edges are ignored. Stored data is kept and reads back unchanged after `pdown` falls.
- R11: A rising edge with `rst_n`=0 clears the array to zero, marks the write buffer empty (no bypass until a write loads it) and turns the output off.
- R12: When a write's data loads the buffer at the same edge as the previous entry commits, a later read compares against the new entry. The previous entry's address reads its committed bytes from the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (4) | Word address of the command |
| sel_n | input | 1 | Active-low command select |
| wen_n | input | 1 | Active-low write enable (1 = read) |
| ben_n | input | LANES (4) | Active-low per-lane write enables |
| din | input | LANES*LANE_W (36) | Write data, one edge after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| pdown | input | 1 | Power-down request, active high |
| dout | output | LANES*LANE_W (36) | Read data, 0 when not driven |
| dout_en | output | 1 | Drive-enable for the data pads |

## Verification
A stale or wrongly loaded write buffer shows up on the first read of the buffered address: at least one lane is wrong on `dout` one edge after that read is sampled. A missed or early commit shows up only after the next write's data loads, when reading the old address returns array bytes that are wrong. A wrong command-stage state shows on `dout_en` on the edge after the command. The bench compares `dout` and `dout_en` with its behavioural model on every cycle, so each of these errors is caught in the first cycle where it can be seen at the ports.

// File: rtl/lwsram_pkg.sv
// Shared types for the late-write memory.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package lwsram_pkg;

    // Kind of command held in the command stage after a rising edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/lwsram_cmd_stage.sv
// Command stage: registers the command on every rising edge. A deselect,
// or any command while power-down is high, becomes OP_IDLE.
// Assumes: the lane enables are active low and are inverted into a mask here.
module lwsram_cmd_stage
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic [LANES-1:0]  ben_n,
    input  logic              pdown,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mask_q
);

    // Register the kind of command; reset leaves the stage idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else if (pdown || sel_n) begin
            op_q <= OP_IDLE;
        end else begin
            op_q <= wen_n ? OP_READ : OP_WRITE;
        end
    end

    // Register the address and the active-high lane mask (no reset needed).
    always_ff @(posedge clk) begin
        addr_q <= addr;
        mask_q <= ~ben_n;
    end

endmodule

// File: rtl/lwsram_wbuf.sv
// One-entry write buffer. When a write's data loads, the entry held before
// it is offered to the array as a commit in the same edge.
// Assumes: load is high for exactly one edge per write command.
module lwsram_wbuf #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LANES-1:0]  ld_mask,
    input  logic [DW-1:0]     ld_data,
    output logic              b_valid,
    output logic [ADDR_W-1:0] b_addr,
    output logic [LANES-1:0]  b_mask,
    output logic [DW-1:0]     b_data,
    output logic              commit_en
);

    // The old entry goes to the array only at the moment it is replaced.
    assign commit_en = load && b_valid;

    // The valid flag is set by the first load and cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
        end else if (load) begin
            b_valid <= 1'b1;
        end
    end

    // Capture the address, mask and data of the write being deferred.
    always_ff @(posedge clk) begin
        if (load) begin
            b_addr <= ld_addr;
            b_mask <= ld_mask;
            b_data <= ld_data;
        end
    end

endmodule

// File: rtl/lwsram_array.sv
// Storage array made of registers: one write port that is masked per lane,
// and one combinational read port.
// Assumes: WORDS is small enough to build from flops; reset clears all words.
module lwsram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wmask,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] mem [WORDS];

    // Clear on reset; otherwise write only the lanes selected by the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wmask[l]) begin
                    mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Read port that does not wait for a clock.
    assign rdata = mem[raddr];

endmodule

// File: rtl/lwsram_rdpath.sv
// Read path: compares the read address with the buffer, merges lane by lane,
// registers the word and gates it with output enable and power-down.
// Assumes: the buffer and array values seen here are those after the edge
// that sampled the read command.
module lwsram_rdpath #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     arr_rdata,
    input  logic              b_valid,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LANES-1:0]  b_mask,
    input  logic [DW-1:0]     b_data,
    input  logic              oe_n,
    input  logic              pdown,
    output logic [DW-1:0]     dout,
    output logic              dout_en
);

    logic          hit;
    logic [DW-1:0] merged;
    logic [DW-1:0] q;
    logic          q_en;

    // A bypass needs a valid buffer entry whose address equals the read address.
    assign hit = b_valid && (b_addr == rd_addr);

    // Per lane: take the buffered byte if that lane was written, else the array byte.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = (hit && b_mask[i])
                                          ? b_data[i*LANE_W +: LANE_W]
                                          : arr_rdata[i*LANE_W +: LANE_W];
    end

    // Output register: reload on reads only, so repeated reads hold steady.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q_en <= 1'b0;
        end else begin
            q_en <= rd_req;
            if (rd_req) begin
                q <= merged;
            end
        end
    end

    // Asynchronous gating by output enable and power-down.
    assign dout_en = q_en && !oe_n && !pdown;
    assign dout    = dout_en ? q : '0;

endmodule

// File: rtl/lwsram_core.sv
// Top of the late-write pipelined memory: command stage, write buffer,
// storage array and read path.
// Assumes: write data is presented on the edge after its command; pads and
// tristate drivers outside use dout_en.
module lwsram_core
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic [LANES-1:0]  ben_n,
    input  logic [DW-1:0]     din,
    input  logic              oe_n,
    input  logic              pdown,
    output logic [DW-1:0]     dout,
    output logic              dout_en
);

    op_e               op_q;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_mask;
    logic              b_valid;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_mask;
    logic [DW-1:0]     b_data;
    logic              commit_en;
    logic [DW-1:0]     arr_rdata;

    lwsram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .sel_n  (sel_n),
        .wen_n  (wen_n),
        .ben_n  (ben_n),
        .pdown  (pdown),
        .op_q   (op_q),
        .addr_q (cmd_addr),
        .mask_q (cmd_mask)
    );

    lwsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (op_q == OP_WRITE),
        .ld_addr   (cmd_addr),
        .ld_mask   (cmd_mask),
        .ld_data   (din),
        .b_valid   (b_valid),
        .b_addr    (b_addr),
        .b_mask    (b_mask),
        .b_data    (b_data),
        .commit_en (commit_en)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit_en),
        .waddr (b_addr),
        .wmask (b_mask),
        .wdata (b_data),
        .raddr (cmd_addr),
        .rdata (arr_rdata)
    );

    lwsram_rdpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (op_q == OP_READ),
        .rd_addr   (cmd_addr),
        .arr_rdata (arr_rdata),
        .b_valid   (b_valid),
        .b_addr    (b_addr),
        .b_mask    (b_mask),
        .b_data    (b_data),
        .oe_n      (oe_n),
        .pdown     (pdown),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: rtl/lwsram_core_chk.sv
// Checker for lwsram_core, attached by bind. It watches only the top ports.
// Assumes: rst_n is low at time zero.
module lwsram_core_chk #(
    parameter int ADDR_W = 4,
    parameter int DW     = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              sel_n,
    input logic              wen_n,
    input logic              oe_n,
    input logic              pdown,
    input logic [DW-1:0]     dout,
    input logic              dout_en
);

    logic       is_rd;
    logic [2:0] since_rst;

    assign is_rd = !sel_n && wen_n && !pdown;

    // Count edges since reset, saturating, so that $past history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assert_reset_off_R11: assert property (@(posedge clk)
        !rst_n |=> !dout_en);

    assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> ##2 (dout_en || oe_n || pdown));

    assert_idle_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !wen_n) |-> ##2 (!dout_en && dout == '0));

    assert_same_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(is_rd, 2) && $past(is_rd, 3)
         && $past(addr, 2) == $past(addr, 3) && dout_en && $past(dout_en))
        |-> dout == $past(dout));

    assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dout_en && dout == '0));

    assert_pdown_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |-> (!dout_en && dout == '0));

endmodule

bind lwsram_core lwsram_core_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .sel_n   (sel_n),
    .wen_n   (wen_n),
    .oe_n    (oe_n),
    .pdown   (pdown),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/lwsram_core_bench.sv
// Bench for lwsram_core: a behavioural model is stepped once per edge and
// compared with the outputs shortly after each falling edge.
module lwsram_core_bench;

    localparam int ADDR_W = 4;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int WORDS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              sel_n = 1'b1;
    logic              wen_n = 1'b1;
    logic [LANES-1:0]  ben_n = '1;
    logic [DW-1:0]     din = '0;
    logic              oe_n = 1'b0;
    logic              pdown = 1'b0;
    logic [DW-1:0]     dout;
    logic              dout_en;

    always #4 clk = ~clk;

    lwsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lwsram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wen_n(wen_n),
        .ben_n(ben_n), .din(din), .oe_n(oe_n), .pdown(pdown),
        .dout(dout), .dout_en(dout_en)
    );

    // Model state
    logic [DW-1:0]     m_mem [WORDS];
    int                m_op;          // 0 idle, 1 read, 2 write
    logic [ADDR_W-1:0] m_addr;
    logic [LANES-1:0]  m_wmask;
    logic              m_bv;
    logic [ADDR_W-1:0] m_baddr;
    logic [LANES-1:0]  m_bmask;
    logic [DW-1:0]     m_bdata;
    logic [DW-1:0]     m_q;
    logic              m_en;
    logic [DW-1:0]     carry;

    int checks = 0;
    int errors = 0;

    function automatic logic [DW-1:0] m_read(input logic [ADDR_W-1:0] a);
        logic [DW-1:0] r;
        r = m_mem[a];
        if (m_bv && m_baddr == a) begin
            for (int l = 0; l < LANES; l++) begin
                if (m_bmask[l]) r[l*LANE_W +: LANE_W] = m_bdata[l*LANE_W +: LANE_W];
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int i);
        logic [DW-1:0] p;
        for (int l = 0; l < LANES; l++) p[l*LANE_W +: LANE_W] = LANE_W'(i * 37 + l * 91 + 5);
        return p;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < WORDS; w++) m_mem[w] = '0;
        m_op = 0; m_addr = '0; m_wmask = '0;
        m_bv = 1'b0; m_baddr = '0; m_bmask = '0; m_bdata = '0;
        m_q = '0; m_en = 1'b0;
    endtask

    task automatic check(input string tag);
        logic          e_en;
        logic [DW-1:0] e_d;
        e_en = m_en && !oe_n && !pdown;
        e_d  = e_en ? m_q : '0;
        checks++;
        if (dout_en !== e_en || dout !== e_d) begin
            errors++;
            $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
                     tag, dout_en, dout, e_en, e_d);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then step the model at the rising edge.
    task automatic step(input string tag, input logic s_n, input logic w_n,
                        input logic [LANES-1:0] b_n, input logic [ADDR_W-1:0] a,
                        input logic oe, input logic pd);
        @(negedge clk);
        sel_n = s_n; wen_n = w_n; ben_n = b_n; addr = a;
        oe_n = oe; pdown = pd; din = carry; carry = '0;
        #2;
        check(tag);
        @(posedge clk);
        if (m_op == 1) m_q = m_read(m_addr);
        m_en = (m_op == 1);
        if (m_op == 2) begin
            if (m_bv) begin
                for (int l = 0; l < LANES; l++)
                    if (m_bmask[l]) m_mem[m_baddr][l*LANE_W +: LANE_W] = m_bdata[l*LANE_W +: LANE_W];
            end
            m_bv = 1'b1; m_baddr = m_addr; m_bmask = m_wmask; m_bdata = din;
        end
        if (pd || s_n) m_op = 0;
        else m_op = w_n ? 1 : 2;
        m_addr = a; m_wmask = ~b_n;
    endtask

    task automatic rd(input string tag, input logic [ADDR_W-1:0] a);
        step(tag, 1'b0, 1'b1, '1, a, 1'b0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [ADDR_W-1:0] a,
                      input logic [LANES-1:0] b_n, input logic [DW-1:0] d);
        step(tag, 1'b0, 1'b0, b_n, a, 1'b0, 1'b0);
        carry = d;
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b1, 1'b1, '1, '0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL R6: watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        carry = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R11 reset state");

        // Array cleared, buffer empty
        rd("R11", 4'd2);
        idle("R11 read of cleared word");
        idle("R7");

        // Back-to-back full writes, each with data on the following edge
        for (int i = 0; i < WORDS; i++) wr("R2", ADDR_W'(i), '0, pat(i));
        idle("R7 after write");
        for (int i = 0; i < WORDS; i++) rd("R3", ADDR_W'(i));
        idle("R6 last read");
        idle("R7");

        // Partial write and byte-lane bypass (lanes 0 and 2 written)
        wr("R5", 4'd3, 4'b1010, 36'h1_2345_6789);
        idle("R1");
        rd("R4", 4'd3);
        rd("R4", 4'd3);
        rd("R8", 4'd3);
        idle("R8");
        idle("R3 reads pending");
        rd("R3", 4'd3);
        idle("R3");

        // Next write commits the buffer in the same edge as it loads
        wr("R12", 4'd5, 4'b0000, 36'hA_BCDE_F012);
        rd("R12", 4'd3);
        rd("R12", 4'd5);
        idle("R12");
        wr("R12", 4'd7, 4'b0110, 36'h5_5555_5555);
        rd("R12", 4'd7);
        rd("R12", 4'd5);
        idle("R12");

        // Write with every lane disabled
        wr("R5", 4'd9, 4'b1111, 36'hF_FFFF_FFFF);
        rd("R5", 4'd9);
        wr("R5", 4'd10, 4'b0000, 36'h0_F0F0_F0F0);
        rd("R5", 4'd9);
        rd("R5", 4'd10);
        idle("R7");

        // Asynchronous output enable
        rd("R9", 4'd4);
        step("R9 oe high", 1'b0, 1'b1, '1, 4'd4, 1'b1, 1'b0);
        step("R9 oe low", 1'b0, 1'b1, '1, 4'd4, 1'b0, 1'b0);
        step("R9 oe high idle", 1'b1, 1'b1, '1, 4'd0, 1'b1, 1'b0);
        idle("R9");

        // Power-down: outputs off, write attempt ignored, data kept
        rd("R10", 4'd4);
        step("R10 pdown", 1'b0, 1'b0, 4'b0000, 4'd4, 1'b0, 1'b1);
        carry = 36'h0_0000_0BAD;
        step("R10 pdown", 1'b0, 1'b1, '1, 4'd4, 1'b0, 1'b1);
        step("R10 pdown", 1'b0, 1'b0, 4'b0000, 4'd6, 1'b0, 1'b1);
        step("R10 wake", 1'b1, 1'b1, '1, 4'd0, 1'b0, 1'b0);
        rd("R10", 4'd4);
        rd("R10", 4'd6);
        idle("R10");

        // Final sweep of every word
        for (int i = 0; i < WORDS; i++) rd("R3 sweep", ADDR_W'(i));
        idle("R6");
        idle("R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule